// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of sixteen general-purpose pins controlled through a small synchronous register port. Software sets each pin's direction, output value and alternate-function select. It also decides, per pin, how an incoming signal raises an interrupt: an edge of chosen polarity, or a level of chosen polarity. Incoming pin values pass through a two-stage synchronizer. Detected events are latched into a status register. Every status bit whose mask bit is clear feeds a single request line.

Software handles an interrupt in three steps. It reads the status register, clears the bits it has served by writing a word with those bits at zero, and reads the synchronized pin levels through a read-only register. Both-edge detection is left to software, which flips the polarity bit after each event.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0x0000 except the mask register, which reads 0xFFFF. The request line is low while every mask bit is 1.
- R2: The direction register (word 0, 1 = output) drives `pin_oe`, the output register (word 1) drives `pin_out`, and the alternate-function register (word 2) drives `pin_alt`. A write is visible on the ports and on readback from the cycle after the write edge.
- R3: The pin-status register (word 7, read-only) returns `pin_in` through two flops. A change applied before clock edge k reads back after edge k+1.
- R4: With trigger-type bit 1 (word 4) and edge bit 1 (word 5), a rising transition of the synchronized pin sets its status bit (word 8) after edge k+2, where k is the first edge that samples the new pin value.
- R5: With trigger-type bit 1 and edge bit 0, only a falling transition sets the status bit, with the same timing as R4. A rising transition leaves the bit unchanged.
- R6: With trigger-type bit 0, the status bit is set on every cycle in which the synchronized pin equals the level bit (word 6; 1 = active-high, 0 = active-low). Because of this, with all registers at reset values, low pins set their status bits on the first cycle after reset.
- R7: A write to the status register keeps only the bits that are 1 in the written word, so writing 0x0000 clears them all. An event in the same cycle as the write sets its bit regardless of the write.
- R8: `irq_req` is high exactly when some status bit is 1 and its mask bit (word 3) is 0. It follows a status or mask change in the same cycle.
- R9: Words 9 to 15 read 0x0000. A write to them, or to the pin-status word, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin inputs |
| pin_out | output | 16 | Output values |
| pin_oe | output | 16 | Output enables, 1 = drive |
| pin_alt | output | 16 | Alternate-function selects |
| irq_req | output | 1 | Bank interrupt request |

## Verification
Register writes show up one edge later. Read data and the request line follow their sources in the same cycle. A pin change reaches the pin-status word two edges after it is first sampled, and sets an edge or level status bit on the following edge.

A behavioural model in the bench steps through the same edge count. Its results are compared with every output 2 ns after each rising edge, once all updates have settled. Inputs change only on falling edges. Directed reads sample one nanosecond after a falling edge, and each is placed at least four edges after the pin change it observes, so every result is already due when it is read.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int W  = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pin_alt,
  output logic          irq_req
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_ALT  = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_TRIG = AW'(4);
  localparam logic [AW-1:0] A_EDGE = AW'(5);
  localparam logic [AW-1:0] A_LVL  = AW'(6);
  localparam logic [AW-1:0] A_PIN  = AW'(7);
  localparam logic [AW-1:0] A_STAT = AW'(8);

  logic [W-1:0] dir_q, out_q, alt_q, mask_q, trig_q, edge_q, lvl_q, stat_q;
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] edge_ev, lvl_ev, ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign edge_ev = trig_q & ((edge_q & sync_q & ~prev_q) | (~edge_q & ~sync_q & prev_q));
  assign lvl_ev  = ~trig_q & ~(sync_q ^ lvl_q);
  assign ev      = edge_ev | lvl_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      alt_q  <= '0;
      mask_q <= '1;
      trig_q <= '0;
      edge_q <= '0;
      lvl_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_DIR:   dir_q  <= reg_wdata;
        A_OUT:   out_q  <= reg_wdata;
        A_ALT:   alt_q  <= reg_wdata;
        A_MASK:  mask_q <= reg_wdata;
        A_TRIG:  trig_q <= reg_wdata;
        A_EDGE:  edge_q <= reg_wdata;
        A_LVL:   lvl_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (reg_wr && reg_addr == A_STAT) stat_q <= (stat_q & reg_wdata) | ev;
    else stat_q <= stat_q | ev;
  end

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_OUT:   reg_rdata = out_q;
      A_ALT:   reg_rdata = alt_q;
      A_MASK:  reg_rdata = mask_q;
      A_TRIG:  reg_rdata = trig_q;
      A_EDGE:  reg_rdata = edge_q;
      A_LVL:   reg_rdata = lvl_q;
      A_PIN:   reg_rdata = sync_q;
      A_STAT:  reg_rdata = stat_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign pin_alt = alt_q;
  assign irq_req = |(stat_q & ~mask_q);

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_DIR) |=> $stable(pin_oe));

  // R9
  unused_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr > A_STAT || reg_addr == A_PIN))
      |=> $stable({dir_q, out_q, alt_q, mask_q, trig_q, edge_q, lvl_q}));

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STAT && reg_wdata == '0 && ev == '0) |=> stat_q == '0);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((stat_q & $past(ev)) == $past(ev)));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(ev)) == '0));

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_req);
endmodule

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, pin_alt;
  logic        irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  gpio_irq_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_alt(pin_alt), .irq_req(irq_req)
  );

  always #4 clk = ~clk;

  // reference model, indexed by word address
  logic [15:0] m_reg [0:8];
  logic [15:0] m_s1, m_s2, m_prev;

  function automatic logic [15:0] m_read(input logic [3:0] a);
    if (a == 4'd7) return m_s2;
    if (a <= 4'd8) return m_reg[a];
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [15:0] ev;
    if (!rst_n) begin
      for (int i = 0; i < 9; i++) m_reg[i] = 16'h0000;
      m_reg[3] = 16'hFFFF;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      ev = 0;
      for (int b = 0; b < 16; b++) begin
        if (m_reg[4][b]) begin
          if (m_reg[5][b] && m_s2[b] && !m_prev[b]) ev[b] = 1;
          if (!m_reg[5][b] && !m_s2[b] && m_prev[b]) ev[b] = 1;
        end else if (m_s2[b] == m_reg[6][b]) ev[b] = 1;
      end
      if (reg_wr && reg_addr == 4'd8) m_reg[8] = (m_reg[8] & reg_wdata) | ev;
      else m_reg[8] = m_reg[8] | ev;
      if (reg_wr && reg_addr < 4'd7) m_reg[reg_addr] = reg_wdata;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      #2;
      chk("R2/R3/R6/R7/R9 rdata", reg_rdata, m_read(reg_addr));
      chk("R2 pin_oe", pin_oe, m_reg[0]);
      chk("R2 pin_out", pin_out, m_reg[1]);
      chk("R2 pin_alt", pin_alt, m_reg[2]);
      chk("R8 irq_req", {15'd0, irq_req}, {15'd0, |(m_reg[8] & ~m_reg[3])});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd(4'd3, 16'hFFFF, "R1 mask reset");
    rd(4'd0, 16'h0000, "R1 dir reset");
    rd(4'd4, 16'h0000, "R1 trig reset");
    chk("R1 irq low", {15'd0, irq_req}, 16'h0000);
    // R6 active-low level with low pins sets every bit
    rd(4'd8, 16'hFFFF, "R6 low level after reset");
    // R2 pin controls
    wr(4'd0, 16'h00F0);
    wr(4'd1, 16'h0A5A);
    wr(4'd2, 16'h8001);
    chk("R2 oe", pin_oe, 16'h00F0);
    chk("R2 out", pin_out, 16'h0A5A);
    chk("R2 alt", pin_alt, 16'h8001);
    // R7 event wins over clear
    wr(4'd8, 16'h0000);
    rd(4'd8, 16'hFFFF, "R7 event beats clear");
    wr(4'd4, 16'hFFFF);
    wr(4'd5, 16'h00FF);
    wr(4'd8, 16'h0000);
    rd(4'd8, 16'h0000, "R7 clear");
    // R3 / R4 rising edges
    pins(16'h0003);
    rd(4'd7, 16'h0003, "R3 pin status");
    rd(4'd8, 16'h0003, "R4 rising sets");
    wr(4'd3, 16'hFFFE);
    chk("R8 unmasked irq", {15'd0, irq_req}, 16'h0001);
    wr(4'd3, 16'hFFFF);
    chk("R8 masked irq", {15'd0, irq_req}, 16'h0000);
    // R5 falling edges only
    wr(4'd8, 16'h0000);
    pins(16'h0303);
    rd(4'd8, 16'h0000, "R5 rising ignored");
    pins(16'h0003);
    rd(4'd8, 16'h0300, "R5 falling sets");
    wr(4'd8, 16'h0100);
    rd(4'd8, 16'h0100, "R7 partial keep");
    // R6 active-high level
    pins(16'h0000);
    wr(4'd6, 16'hFFFF);
    wr(4'd4, 16'h0000);
    wr(4'd8, 16'h0000);
    rd(4'd8, 16'h0000, "R6 no level yet");
    pins(16'h8000);
    rd(4'd8, 16'h8000, "R6 high level sets");
    wr(4'd8, 16'h0000);
    rd(4'd8, 16'h8000, "R6 level persists");
    // R9 ignored writes
    wr(4'd7, 16'h1234);
    wr(4'd12, 16'h1234);
    rd(4'd12, 16'h0000, "R9 unused reads zero");
    rd(4'd7, 16'h8000, "R9 pin status read-only");
    rd(4'd0, 16'h00F0, "R9 dir untouched");
    rd(4'd3, 16'hFFFF, "R9 mask untouched");
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule